// File: doc/BRIEF.md
# Multiplexed-address DRAM bank front end

This block sits between a 20-bit processor address bus and four banks of multiplexed-address DRAM. The address space is 1 MB. A sixteen-slot map is indexed by the top four address bits, so it works in 64 KB regions. Each slot says whether on-board memory answers that region, and which of the four banks does so. The block turns that answer into a registered memory-select flag, a bank number, and one active-low row strobe and one active-low column strobe per bank. It also drives a nine-bit DRAM address bus that is time-shared between the row phase and the column phase.

The ninth DRAM address pin carries one processor address bit in the row phase and the next bit up in the column phase. That pin is what lets a bank hold either 64K or 256K devices. The map alone decides how large a bank is. A bank acts as 256K only when four regions of the map point at it.

Requests arrive on a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` then stays low for the four cycles of the strobe sequence. The requester must hold `req_valid` and `req_addr` steady until the request is taken. The map is loaded through a separate write port.

Top module: `dram_front_end`

## Requirements
- R1: After reset, map slots 0 to 3 select banks 0 to 3, every other slot is deselected, all strobes are high, `mem_sel` is low and `req_ready` is high.
- R2: A map write on a rising edge with `map_wr_en` high replaces slot `map_wr_idx` with the select flag `map_wr_sel` and the bank number `map_wr_bank`. Requests taken afterwards use the new contents.
- R3: `mem_sel` equals the select flag of the slot addressed by `req_addr[19:16]`. It holds that value from the first cycle after the request is taken through the CAS cycle, and it is low when the block is idle.
- R4: During a request, `bank_num` shows the bank number stored in the addressed slot.
- R5: At most one bit of `ras_n` is low at a time, and at most one bit of `cas_n` is low at a time. For a selected request, bit `bank_num` of `ras_n` goes low in the second cycle after the request is taken.
- R6: `col_phase` goes high one cycle after RAS asserts. CAS of the same bank asserts one cycle after that. CAS is never low unless RAS of the same bank is low and `col_phase` is high.
- R7: In the row phase, `dram_addr` is {`req_addr[16]`, `req_addr[7:0]`}. In the column phase it is {`req_addr[17]`, `req_addr[15:8]`}.
- R8: If the addressed slot is deselected, no strobe falls during the request.
- R9: RAS and CAS release together in the fifth cycle after the request is taken. In that same cycle `req_ready` returns high and `col_phase` returns low.
- R10: `req_ready` is low for the four cycles of the strobe sequence. Each handshake produces exactly one strobe sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| map_wr_en | input | 1 | Map slot write strobe |
| map_wr_idx | input | 4 | Map slot to write |
| map_wr_sel | input | 1 | Select flag to store |
| map_wr_bank | input | 2 | Bank number to store |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 20 | Request byte address |
| mem_sel | output | 1 | On-board memory answers this access |
| bank_num | output | 2 | Bank chosen by the map |
| col_phase | output | 1 | 0 for the row phase, 1 for the column phase |
| dram_addr | output | 9 | Multiplexed DRAM address |
| ras_n | output | 4 | Row strobes, one per bank, active low |
| cas_n | output | 4 | Column strobes, one per bank, active low |

## Verification
The bench remaps four consecutive regions onto one bank. It then requests one address in each region, so that the ninth address pin takes all four combinations of row and column value. A multiplexer that fed the same bit into both phases would show up as two of those addresses with the same pin values.

It also clears a reset-time slot and then requests that region. A design that fired strobes without checking the select flag would pull a RAS line low there.

Each request is checked cycle by cycle. A design that raised CAS before the column address was on the bus, or that released the two strobes in different cycles, breaks the expected sequence. Back-to-back requests, with `req_valid` raised while the block is busy, catch a ready signal that lets a request in during a sequence that is still running.

// File: rtl/dram_fe_pkg.sv
package dram_fe_pkg;
  localparam int BANK_W = 2;
  localparam int NBANK  = 1 << BANK_W;

  typedef struct packed {
    logic              sel;
    logic [BANK_W-1:0] bank;
  } map_slot_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ROW  = 3'd1,
    S_RAS  = 3'd2,
    S_COL  = 3'd3,
    S_CAS  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/bank_map_regs.sv
module bank_map_regs
  import dram_fe_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  map_slot_t        wr_slot,
  input  logic [IDX_W-1:0] rd_idx,
  output map_slot_t        rd_slot
);
  localparam int NSLOT = 1 << IDX_W;

  map_slot_t slots_q [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam map_slot_t RST_VAL = (i < NBANK) ?
      map_slot_t'{sel: 1'b1, bank: BANK_W'(i)} : map_slot_t'{sel: 1'b0, bank: '0};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slots_q[i] <= RST_VAL;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        slots_q[i] <= wr_slot;
    end
  end

  assign rd_slot = slots_q[rd_idx];

  // R2: a write shows up at the read port of the same slot one cycle later.
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_idx == wr_idx) |=>
      ($stable(rd_idx) -> rd_slot == $past(wr_slot)));
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
  import dram_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              ras_en_i,
  input  logic              cas_en_i,
  output logic [NBANK-1:0]  ras_n_o,
  output logic [NBANK-1:0]  cas_n_o
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ras_n_o[b] <= 1'b1;
        cas_n_o[b] <= 1'b1;
      end else begin
        ras_n_o[b] <= !(ras_en_i && bank_i == BANK_W'(b));
        cas_n_o[b] <= !(cas_en_i && bank_i == BANK_W'(b));
      end
    end
  end

  // R5: never more than one bank strobed.
  a_r5_ras_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ras_n_o) <= 1);
  a_r5_cas_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cas_n_o) <= 1);
endmodule

// File: rtl/row_col_mux.sv
module row_col_mux #(
  parameter int ADDR_W = 20,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              col_i,
  output logic [COL_W:0]    dram_addr_o,
  output logic              col_phase_o
);
  localparam int HI_ROW = 2 * COL_W;
  localparam int HI_COL = 2 * COL_W + 1;

  logic [COL_W:0] row_word, col_word;
  assign row_word = {addr_i[HI_ROW], addr_i[COL_W-1:0]};
  assign col_word = {addr_i[HI_COL], addr_i[2*COL_W-1:COL_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dram_addr_o <= '0;
      col_phase_o <= 1'b0;
    end else begin
      dram_addr_o <= col_i ? col_word : row_word;
      col_phase_o <= col_i;
    end
  end

  // R7: the address bus changes only when the phase changes or a new address arrives.
  a_r7_addr_follows_phase: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(col_i) && $stable(addr_i)) |=> $stable(dram_addr_o));
endmodule

// File: rtl/dram_front_end.sv
module dram_front_end
  import dram_fe_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int IDX_W  = 4,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_wr_en,
  input  logic [IDX_W-1:0]  map_wr_idx,
  input  logic              map_wr_sel,
  input  logic [BANK_W-1:0] map_wr_bank,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              mem_sel,
  output logic [BANK_W-1:0] bank_num,
  output logic              col_phase,
  output logic [COL_W:0]    dram_addr,
  output logic [NBANK-1:0]  ras_n,
  output logic [NBANK-1:0]  cas_n
);
  seq_state_t state_q, state_d;
  map_slot_t  lk_slot, wr_slot;
  logic              accept;
  logic              sel_q, sel_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              ras_en_d, cas_en_d, col_d;

  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign wr_slot   = '{sel: map_wr_sel, bank: map_wr_bank};

  bank_map_regs #(.IDX_W(IDX_W)) map_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(map_wr_en), .wr_idx(map_wr_idx), .wr_slot(wr_slot),
    .rd_idx(req_addr[ADDR_W-1 -: IDX_W]), .rd_slot(lk_slot)
  );

  always_comb begin
    unique case (state_q)
      S_IDLE:  state_d = accept ? S_ROW : S_IDLE;
      S_ROW:   state_d = S_RAS;
      S_RAS:   state_d = S_COL;
      S_COL:   state_d = S_CAS;
      default: state_d = S_IDLE;
    endcase
  end

  assign sel_d  = accept ? lk_slot.sel  : sel_q;
  assign bank_d = accept ? lk_slot.bank : bank_q;
  assign addr_d = accept ? req_addr     : addr_q;

  assign ras_en_d = sel_d && (state_d == S_RAS || state_d == S_COL || state_d == S_CAS);
  assign cas_en_d = sel_d && (state_d == S_CAS);
  assign col_d    = (state_d == S_COL || state_d == S_CAS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sel_q   <= 1'b0;
      bank_q  <= '0;
      addr_q  <= '0;
      mem_sel <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      bank_q  <= bank_d;
      addr_q  <= addr_d;
      mem_sel <= sel_d && (state_d != S_IDLE);
    end
  end

  assign bank_num = bank_q;

  strobe_decode strobe_i (
    .clk(clk), .rst_n(rst_n),
    .bank_i(bank_d), .ras_en_i(ras_en_d), .cas_en_i(cas_en_d),
    .ras_n_o(ras_n), .cas_n_o(cas_n)
  );

  row_col_mux #(.ADDR_W(ADDR_W), .COL_W(COL_W)) mux_i (
    .clk(clk), .rst_n(rst_n),
    .addr_i(addr_d), .col_i(col_d),
    .dram_addr_o(dram_addr), .col_phase_o(col_phase)
  );

  // R6: CAS only on a bank whose RAS is low, and only in the column phase.
  a_r6_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    ((~cas_n & ras_n) == '0) && ((cas_n == '1) || col_phase));
  // R8: a deselected access strobes nothing.
  a_r8_quiet_when_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_sel |-> (ras_n == '1 && cas_n == '1));
  // R9: when ready for a new request, every strobe is released.
  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ras_n == '1 && cas_n == '1 && !col_phase));
  // R10: a taken request makes ready drop on the next cycle.
  a_r10_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/dram_front_end_tb_top.sv
`timescale 1ns/1ps
module dram_front_end_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_wr_en = 1'b0;
  logic [3:0]  map_wr_idx = '0;
  logic        map_wr_sel = 1'b0;
  logic [1:0]  map_wr_bank = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        mem_sel;
  logic [1:0]  bank_num;
  logic        col_phase;
  logic [8:0]  dram_addr;
  logic [3:0]  ras_n, cas_n;

  always #2 clk = ~clk;

  dram_front_end dut_i (
    .clk(clk), .rst_n(rst_n),
    .map_wr_en(map_wr_en), .map_wr_idx(map_wr_idx),
    .map_wr_sel(map_wr_sel), .map_wr_bank(map_wr_bank),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .mem_sel(mem_sel), .bank_num(bank_num), .col_phase(col_phase),
    .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n)
  );

  typedef struct {
    logic       sel;
    logic [1:0] bank;
    logic [8:0] row;
    logic [8:0] col;
  } exp_t;

  exp_t exp_q[$];
  logic [2:0] shadow [16];
  int checks = 0, errors = 0, sent = 0, taken = 0;
  bit done = 0, rel_pending = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic map_write(input int idx, input bit sel, input int bank);
    @(posedge clk); #1;
    map_wr_en = 1'b1; map_wr_idx = 4'(idx); map_wr_sel = sel; map_wr_bank = 2'(bank);
    @(posedge clk); #1;
    map_wr_en = 1'b0;
    shadow[idx] = {sel, 2'(bank)};
  endtask

  task automatic send(input logic [19:0] a);
    exp_t e;
    e.sel  = shadow[a[19:16]][2];
    e.bank = shadow[a[19:16]][1:0];
    e.row  = {a[16], a[7:0]};
    e.col  = {a[17], a[15:8]};
    exp_q.push_back(e);
    sent++;
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // Monitor: pops the expected item on every handshake and checks each phase.
  initial begin
    exp_t e;
    logic [3:0] ras_exp, cas_exp;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rel_pending && req_ready) begin
          chk(ras_n == 4'hF && cas_n == 4'hF && !col_phase && !mem_sel, "R9 release",
              {ras_n, cas_n, 3'b0, col_phase}, 32'hFF0);
          rel_pending = 0;
        end
        if (req_valid && req_ready) begin
          taken++;
          if (exp_q.size() == 0) begin
            chk(0, "R10 unexpected handshake", 32'(taken), 32'(sent));
          end else begin
            e = exp_q.pop_front();
            ras_exp = e.sel ? ~(4'b1 << e.bank) : 4'hF;
            cas_exp = ras_exp;
            @(negedge clk); // row set up, no strobe
            chk(mem_sel == e.sel, "R3 mem_sel", 32'(mem_sel), 32'(e.sel));
            if (e.sel) chk(bank_num == e.bank, "R4 bank_num", 32'(bank_num), 32'(e.bank));
            chk(ras_n == 4'hF && cas_n == 4'hF, "R5 no early strobe", {ras_n, cas_n}, 32'hFF);
            chk(!col_phase && dram_addr == e.row, "R7 row address", {col_phase, dram_addr}, 32'(e.row));
            chk(!req_ready, "R10 busy", 32'(req_ready), 0);
            @(negedge clk); // RAS
            chk(ras_n == ras_exp && cas_n == 4'hF, e.sel ? "R5 RAS asserts" : "R8 no RAS",
                {ras_n, cas_n}, {ras_exp, 4'hF});
            chk(!col_phase && dram_addr == e.row, "R7 row held", {col_phase, dram_addr}, 32'(e.row));
            chk(mem_sel == e.sel && !req_ready, "R3 select held", {mem_sel, req_ready}, {e.sel, 1'b0});
            @(negedge clk); // column phase
            chk(col_phase && dram_addr == e.col, "R7 column address", {col_phase, dram_addr}, {1'b1, e.col});
            chk(ras_n == ras_exp && cas_n == 4'hF, "R6 CAS waits for column", {ras_n, cas_n}, {ras_exp, 4'hF});
            @(negedge clk); // CAS
            chk(ras_n == ras_exp && cas_n == cas_exp, e.sel ? "R6 CAS asserts" : "R8 no CAS",
                {ras_n, cas_n}, {ras_exp, cas_exp});
            chk(col_phase && dram_addr == e.col && !req_ready, "R10 column held busy",
                {req_ready, col_phase, dram_addr}, {2'b01, e.col});
            rel_pending = 1;
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = (i < 4) ? {1'b1, 2'(i)} : 3'b000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n == 4'hF && cas_n == 4'hF && !mem_sel && req_ready, "R1 reset outputs",
        {ras_n, cas_n, 2'b0, mem_sel, req_ready}, 32'hFF1);

    // R1: reset map, one address per reset-time region plus a deselected one.
    send(20'h0_1234);
    send(20'h1_ABCD);
    send(20'h2_5A5A);
    send(20'h3_FF00);
    send(20'h5_0101);   // R8: slot 5 is deselected at reset
    send(20'hF_FFFF);   // R8: top region deselected

    // R2/R7: four regions on bank 2 form a 256K bank; pin 8 takes all four combinations.
    for (int r = 4; r < 8; r++) map_write(r, 1'b1, 2);
    send(20'h4_3C96);
    send(20'h5_3C96);
    send(20'h6_3C96);
    send(20'h7_3C96);

    // R2/R8: clear slot 0, which selected bank 0 after reset.
    map_write(0, 1'b0, 0);
    send(20'h0_0042);

    // R2: move slot 3 to bank 1.
    map_write(3, 1'b1, 1);
    send(20'h3_8001);

    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R10 all requests served", 32'(exp_q.size()), 0);
    chk(taken == sent, "R10 one sequence per handshake", 32'(taken), 32'(sent));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule